// File: doc/BRIEF.md
# Dual-Bank Digital Loop Compensator

This block closes the voltage loop of a switching power converter in the digital domain. Once per switching cycle a strobe marks the start of a new cycle. On that strobe the block takes one signed error sample and updates an integrator and a pole/zero section. Two clock edges after the strobe it presents a new unsigned duty command, with a one-cycle valid pulse. Between strobes the duty command holds its value.

The response adds an integrating branch to a pole/zero branch. The integrating branch has gain `gi`. The pole/zero branch has a pole `pq` and a zero `zq`, both Q0.8 fractions, and a high-frequency gain `gh`. A 2-bit band code scales the result up by 1, 2, 4 or 8 to suit the switching-frequency range. The result is then clamped to a programmable window. Two full coefficient sets are held: one for normal load and one for light load. The light set is picked when the reported load level falls below a programmable threshold. While soft start is active, a reduced filter with only an integrating term is used instead. A write port stages all settings, and the staged settings take effect together at the next strobe.

Top module: `dual_bank_comp`

## Requirements
- R1: While `rst` is high and after it falls, `duty` is 0 and `duty_valid` is 0. The integrator, pole/zero state, both error samples and all staged settings are 0, except the duty maximum, which is 4095. The first update after reset therefore starts from zero state.
- R2: A strobe sampled on a `cyc_start` edge yields exactly one `duty_valid` pulse, in the cycle after the next edge. `duty` changes only together with that pulse.
- R3: On each update, the integrator becomes sat(I + gi·e). Here e is the sample taken at the strobe, and sat limits the value to the signed ACC_W range.
- R4: On each update, the pole/zero state becomes sat(((pq·P) >>> 8) + gh·(e − ((zq·e_prev) >>> 8))). Here e_prev is the sample from the previous strobe, pq and zq are unsigned values read as value/256, and >>> is an arithmetic shift that rounds toward minus infinity.
- R5: The duty before clamping is ((I + P) <<< band_sel) >>> OUT_SHIFT, using the new state values. `band_sel` codes 0, 1, 2 and 3 scale by 1, 2, 4 and 8.
- R6: The pre-clamp value is first limited to at most the duty maximum and then raised to at least the duty minimum. When the minimum exceeds the maximum, the minimum wins.
- R7: Register map, all fields in the low bits of `wr_data`: address 0 is normal gi, 1 is normal gh, 2 is normal zq and 3 is normal pq. Addresses 4 to 7 hold the same four fields for the light set. Address 8 is the soft-start gain in bits [1:0], 9 is the load threshold, 10 is the duty minimum and 11 is the duty maximum. The light set is used when `load_level` is strictly below the threshold at the strobe; otherwise the normal set is used.
- R8: When `soft_start` is high at the strobe, pq, zq and gh are taken as 0 and gi is the 2-bit soft-start gain. The pole/zero state therefore becomes 0.
- R9: Changing the coefficient set, whether by load level or by soft start, never clears the integrator or the stored error sample.
- R10: Writes are staged. A write in the same cycle as the strobe is part of that commit. A write in any later cycle has no effect on results until the following strobe.
- R11: The integrator and pole/zero state saturate at the signed ACC_W limits instead of wrapping. A positive overflow holds the largest value, and a negative overflow holds the smallest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-cycle strobe at the start of a switching cycle |
| err_in | input | ERR_W | Signed voltage error sample |
| band_sel | input | 2 | Frequency band code, scale 2^band_sel |
| load_level | input | LOAD_W | Current modulation or load level |
| soft_start | input | 1 | Soft start active |
| wr_en | input | 1 | Settings write enable |
| wr_addr | input | 4 | Settings address |
| wr_data | input | DATA_W | Settings data |
| duty | output | DUTY_W | Registered duty command |
| duty_valid | output | 1 | One-cycle pulse when `duty` has been updated |

## Verification
Two functions can fall in the same cycle: a settings write and the commit done by the cycle-start strobe. The bench drives a write together with the strobe and checks that the new value already shapes that result. It also drives a write in the cycle between the strobe and the result, and checks that this result still uses the earlier value while the next strobe picks it up. A second pair is a load-level change and soft start arriving on the same strobe. The bench judges this pair by checking that the integrator carries on without a step, using a bit-accurate difference-equation model kept inside the bench.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;
  // Q0.8 pole and zero format and gain field width are fixed by the register map
  localparam int COEF_W = 8;
  localparam int FRAC_W = 8;
  localparam int SSG_W  = 2;
  localparam int ADDR_W = 4;
  localparam int NCOEF  = 4;
  localparam int NSLOT  = 2 * NCOEF;

  localparam logic [ADDR_W-1:0] A_SSG  = 4'd8;
  localparam logic [ADDR_W-1:0] A_THR  = 4'd9;
  localparam logic [ADDR_W-1:0] A_DMIN = 4'd10;
  localparam logic [ADDR_W-1:0] A_DMAX = 4'd11;

  // one coefficient set: integrator gain, high-frequency gain, zero, pole
  typedef struct packed {
    logic [COEF_W-1:0] gi;
    logic [COEF_W-1:0] gh;
    logic [COEF_W-1:0] zq;
    logic [COEF_W-1:0] pq;
  } coef_t;
endpackage

// File: rtl/lc_coef_bank.sv
`timescale 1ns/1ps
module lc_coef_bank import lc_pkg::*; #(
  parameter int DATA_W = 12,
  parameter int LOAD_W = 12,
  parameter int DUTY_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic [LOAD_W-1:0] load_level,
  input  logic              soft_start,
  output coef_t             eff,
  output logic              ss_q,
  output logic [DUTY_W-1:0] dmin,
  output logic [DUTY_W-1:0] dmax
);
  logic [COEF_W-1:0] stg [NSLOT];
  logic [COEF_W-1:0] wt  [NSLOT];
  logic [SSG_W-1:0]  ssg_stg, ssg_wt;
  logic [LOAD_W-1:0] thr_stg, thr_wt;
  logic [DUTY_W-1:0] dmin_stg, dmin_wt, dmax_stg, dmax_wt;
  coef_t nrm, lgt;
  logic  light_n;

  // staging registers, one write per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) stg[i] <= '0;
      ssg_stg  <= '0;
      thr_stg  <= '0;
      dmin_stg <= '0;
      dmax_stg <= '1;
    end else if (wr_en) begin
      for (int i = 0; i < NSLOT; i++)
        if (wr_addr == ADDR_W'(i)) stg[i] <= wr_data[COEF_W-1:0];
      if (wr_addr == A_SSG)  ssg_stg  <= wr_data[SSG_W-1:0];
      if (wr_addr == A_THR)  thr_stg  <= wr_data[LOAD_W-1:0];
      if (wr_addr == A_DMIN) dmin_stg <= wr_data[DUTY_W-1:0];
      if (wr_addr == A_DMAX) dmax_stg <= wr_data[DUTY_W-1:0];
    end
  end

  // write-through view so a write beside the strobe joins the commit
  always_comb begin
    for (int i = 0; i < NSLOT; i++)
      wt[i] = (wr_en && wr_addr == ADDR_W'(i)) ? wr_data[COEF_W-1:0] : stg[i];
    ssg_wt  = (wr_en && wr_addr == A_SSG)  ? wr_data[SSG_W-1:0]  : ssg_stg;
    thr_wt  = (wr_en && wr_addr == A_THR)  ? wr_data[LOAD_W-1:0] : thr_stg;
    dmin_wt = (wr_en && wr_addr == A_DMIN) ? wr_data[DUTY_W-1:0] : dmin_stg;
    dmax_wt = (wr_en && wr_addr == A_DMAX) ? wr_data[DUTY_W-1:0] : dmax_stg;
  end

  always_comb begin
    nrm.gi = wt[0]; nrm.gh = wt[1]; nrm.zq = wt[2]; nrm.pq = wt[3];
    lgt.gi = wt[NCOEF+0]; lgt.gh = wt[NCOEF+1];
    lgt.zq = wt[NCOEF+2]; lgt.pq = wt[NCOEF+3];
    light_n = load_level < thr_wt;
  end

  // active set, loaded only by the cycle-start strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      eff  <= '0;
      ss_q <= 1'b0;
      dmin <= '0;
      dmax <= '1;
    end else if (commit) begin
      ss_q <= soft_start;
      dmin <= dmin_wt;
      dmax <= dmax_wt;
      if (soft_start) begin
        eff    <= '0;
        eff.gi <= COEF_W'(ssg_wt);
      end else begin
        eff <= light_n ? lgt : nrm;
      end
    end
  end

  // R10
  coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(eff) && $stable(dmin) && $stable(dmax));
endmodule

// File: rtl/lc_datapath.sv
`timescale 1ns/1ps
module lc_datapath import lc_pkg::*; #(
  parameter int ERR_W = 12,
  parameter int ACC_W = 24,
  parameter int W     = 44
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cyc_start,
  input  logic signed [ERR_W-1:0] err_in,
  input  logic [1:0]              band_sel,
  input  coef_t                   eff,
  input  logic                    ss_q,
  output logic                    upd,
  output logic signed [W-1:0]     mix
);
  localparam logic signed [W-1:0] ACC_MAX = {{(W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [W-1:0] ACC_MIN = ~ACC_MAX;

  logic signed [ERR_W-1:0] e_cur, e_prev;
  logic [1:0]              band_q;
  logic signed [ACC_W-1:0] acc_st, p_st, acc_nx, p_nx;
  logic signed [W-1:0] e_w, ep_w, acc_w, p_w, gi_w, gh_w, zq_w, pq_w;
  logic signed [W-1:0] inc, acc_sum, zt, u, pt, p_sum, an_w, pn_w;

  function automatic logic signed [ACC_W-1:0] sat(input logic signed [W-1:0] x);
    if (x > ACC_MAX)      return ACC_MAX[ACC_W-1:0];
    else if (x < ACC_MIN) return ACC_MIN[ACC_W-1:0];
    else                  return x[ACC_W-1:0];
  endfunction

  // sample capture on the strobe, update one edge later
  always_ff @(posedge clk) begin
    if (rst) begin
      e_cur  <= '0;
      e_prev <= '0;
      band_q <= '0;
      upd    <= 1'b0;
    end else begin
      upd <= cyc_start;
      if (cyc_start) begin
        e_prev <= e_cur;
        e_cur  <= err_in;
        band_q <= band_sel;
      end
    end
  end

  always_comb begin
    e_w   = {{(W-ERR_W){e_cur[ERR_W-1]}}, e_cur};
    ep_w  = {{(W-ERR_W){e_prev[ERR_W-1]}}, e_prev};
    acc_w = {{(W-ACC_W){acc_st[ACC_W-1]}}, acc_st};
    p_w   = {{(W-ACC_W){p_st[ACC_W-1]}}, p_st};
    gi_w  = {{(W-COEF_W){1'b0}}, eff.gi};
    gh_w  = {{(W-COEF_W){1'b0}}, eff.gh};
    zq_w  = {{(W-COEF_W){1'b0}}, eff.zq};
    pq_w  = {{(W-COEF_W){1'b0}}, eff.pq};
    // integrating branch
    inc     = gi_w * e_w;
    acc_sum = acc_w + inc;
    acc_nx  = sat(acc_sum);
    // pole/zero branch
    zt    = (zq_w * ep_w) >>> FRAC_W;
    u     = e_w - zt;
    pt    = (pq_w * p_w) >>> FRAC_W;
    p_sum = pt + gh_w * u;
    p_nx  = sat(p_sum);
    an_w  = {{(W-ACC_W){acc_nx[ACC_W-1]}}, acc_nx};
    pn_w  = {{(W-ACC_W){p_nx[ACC_W-1]}}, p_nx};
    mix   = (an_w + pn_w) <<< band_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_st <= '0;
      p_st   <= '0;
    end else if (upd) begin
      acc_st <= acc_nx;
      p_st   <= p_nx;
    end
  end

  // R11
  acc_no_wrap_pos_chk: assert property (@(posedge clk) disable iff (rst)
    upd && !acc_st[ACC_W-1] && !inc[W-1] |=> !acc_st[ACC_W-1]);
  // R11
  acc_no_wrap_neg_chk: assert property (@(posedge clk) disable iff (rst)
    upd && acc_st[ACC_W-1] && inc[W-1] |=> acc_st[ACC_W-1]);
  // R8
  ss_pz_clear_chk: assert property (@(posedge clk) disable iff (rst)
    upd && ss_q |=> p_st == '0);
  // R9
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(acc_st) && $stable(p_st));
endmodule

// File: rtl/lc_duty_out.sv
`timescale 1ns/1ps
module lc_duty_out #(
  parameter int DUTY_W    = 12,
  parameter int W         = 44,
  parameter int OUT_SHIFT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd,
  input  logic signed [W-1:0] mix,
  input  logic [DUTY_W-1:0]   dmin,
  input  logic [DUTY_W-1:0]   dmax,
  output logic [DUTY_W-1:0]   duty,
  output logic                duty_valid
);
  logic signed [W-1:0] raw, hi_w, lo_w, clip1, clip2;

  always_comb begin
    raw   = mix >>> OUT_SHIFT;
    hi_w  = {{(W-DUTY_W){1'b0}}, dmax};
    lo_w  = {{(W-DUTY_W){1'b0}}, dmin};
    clip1 = (raw > hi_w) ? hi_w : raw;
    clip2 = (clip1 < lo_w) ? lo_w : clip1;   // lower bound has the last word
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty       <= '0;
      duty_valid <= 1'b0;
    end else begin
      duty_valid <= upd;
      if (upd) duty <= clip2[DUTY_W-1:0];
    end
  end

  // R2
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(duty));
  // R6
  duty_range_chk: assert property (@(posedge clk) disable iff (rst)
    upd && (dmin <= dmax) |=> (duty <= $past(dmax)) && (duty >= $past(dmin)));
  // R6
  min_wins_chk: assert property (@(posedge clk) disable iff (rst)
    upd && (dmin > dmax) |=> duty == $past(dmin));
  // R6
  clip_width_chk: assert property (@(posedge clk) disable iff (rst)
    upd |-> clip2[W-1:DUTY_W] == '0);
endmodule

// File: rtl/dual_bank_comp.sv
`timescale 1ns/1ps
module dual_bank_comp import lc_pkg::*; #(
  parameter int ERR_W     = 12,
  parameter int ACC_W     = 24,
  parameter int DUTY_W    = 12,
  parameter int LOAD_W    = 12,
  parameter int DATA_W    = 12,
  parameter int OUT_SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cyc_start,
  input  logic signed [ERR_W-1:0] err_in,
  input  logic [1:0]              band_sel,
  input  logic [LOAD_W-1:0]       load_level,
  input  logic                    soft_start,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [DUTY_W-1:0]       duty,
  output logic                    duty_valid
);
  // common datapath width: covers gain products, the pole product and the band shift
  localparam int W = ACC_W + 2 * COEF_W + 4;

  coef_t                eff;
  logic                 ss_q, upd;
  logic [DUTY_W-1:0]    dmin, dmax;
  logic signed [W-1:0]  mix;

  lc_coef_bank #(.DATA_W(DATA_W), .LOAD_W(LOAD_W), .DUTY_W(DUTY_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(cyc_start), .load_level(load_level), .soft_start(soft_start),
    .eff(eff), .ss_q(ss_q), .dmin(dmin), .dmax(dmax));

  lc_datapath #(.ERR_W(ERR_W), .ACC_W(ACC_W), .W(W)) u_dp (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .err_in(err_in),
    .band_sel(band_sel), .eff(eff), .ss_q(ss_q), .upd(upd), .mix(mix));

  lc_duty_out #(.DUTY_W(DUTY_W), .W(W), .OUT_SHIFT(OUT_SHIFT)) u_out (
    .clk(clk), .rst(rst), .upd(upd), .mix(mix), .dmin(dmin), .dmax(dmax),
    .duty(duty), .duty_valid(duty_valid));

  // R2
  valid_timing_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> ##2 duty_valid);
  // R2
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    duty_valid |-> $past(cyc_start, 2));
endmodule

// File: tb/sim_dual_bank_comp.sv
`timescale 1ns/1ps
module sim_dual_bank_comp;
  localparam int  ACC_W = 24;
  localparam int  OSH   = 4;
  localparam longint AMAX = (64'sd1 <<< (ACC_W-1)) - 1;
  localparam longint AMIN = -(64'sd1 <<< (ACC_W-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0;
  logic signed [11:0] err_in = '0;
  logic [1:0]  band_sel = '0;
  logic [11:0] load_level = '0;
  logic soft_start = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [11:0] duty;
  logic duty_valid;

  int errs = 0;
  int checks = 0;
  longint st [12];
  longint act [12];
  longint m_acc, m_p, m_ec, m_ep, m_exp;
  longint last_duty;

  always #10 clk = ~clk;

  dual_bank_comp u0 (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .err_in(err_in),
    .band_sel(band_sel), .load_level(load_level), .soft_start(soft_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .duty(duty), .duty_valid(duty_valid));

  task automatic chk(input string tag, input longint got, input longint exp_v);
    checks++;
    if (got != exp_v) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp_v);
    end
  endtask

  function automatic longint satv(input longint x);
    if (x > AMAX) return AMAX;
    if (x < AMIN) return AMIN;
    return x;
  endfunction

  function automatic longint fmask(input int a, input longint v);
    if (a < 8)  return v & 255;
    if (a == 8) return v & 3;
    return v & 4095;
  endfunction

  // bit-accurate reference of the difference equations (R3, R4, R5, R6, R7, R8)
  task automatic model_commit(input longint e, input longint ld, input bit ss, input int band);
    longint gi, gh, zq, pq, accn, pn, u, s, raw;
    int base;
    for (int i = 0; i < 12; i++) act[i] = st[i];
    base = (ld < act[9]) ? 4 : 0;
    if (ss) begin gi = act[8]; gh = 0; zq = 0; pq = 0; end
    else begin gi = act[base]; gh = act[base+1]; zq = act[base+2]; pq = act[base+3]; end
    m_ep = m_ec;
    m_ec = e;
    accn = satv(m_acc + gi * e);
    u    = e - ((zq * m_ep) >>> 8);
    pn   = satv(((pq * m_p) >>> 8) + gh * u);
    s    = (accn + pn) <<< band;
    raw  = s >>> OSH;
    if (raw > act[11]) raw = act[11];
    if (raw < act[10]) raw = act[10];
    m_acc = accn;
    m_p   = pn;
    m_exp = raw;
  endtask

  task automatic do_write(input int a, input longint v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = v[11:0];
    @(negedge clk);
    wr_en = 1'b0;
    st[a] = fmask(a, v);
  endtask

  // one switching cycle; optional write beside the strobe (co) or one cycle later (lt)
  task automatic step(input longint e, input longint ld, input bit ss, input int band,
                      input bit co_en, input int co_a, input longint co_v,
                      input bit lt_en, input int lt_a, input longint lt_v,
                      input string tag);
    @(negedge clk);
    chk({tag, " R2 idle valid"}, longint'(duty_valid), 0);
    chk({tag, " R2 duty held"}, longint'(duty), last_duty);
    err_in = e[11:0]; load_level = ld[11:0]; soft_start = ss; band_sel = 2'(band);
    cyc_start = 1'b1;
    if (co_en) begin wr_en = 1'b1; wr_addr = 4'(co_a); wr_data = co_v[11:0]; end
    @(negedge clk);
    cyc_start = 1'b0; wr_en = 1'b0;
    if (co_en) st[co_a] = fmask(co_a, co_v);
    model_commit(e, ld, ss, band);
    if (lt_en) begin wr_en = 1'b1; wr_addr = 4'(lt_a); wr_data = lt_v[11:0]; end
    @(negedge clk);
    wr_en = 1'b0;
    if (lt_en) st[lt_a] = fmask(lt_a, lt_v);
    chk({tag, " duty"}, longint'(duty), m_exp);
    chk({tag, " R2 valid pulse"}, longint'(duty_valid), 1);
    last_duty = longint'(duty);
  endtask

  task automatic run(input longint e, input longint ld, input bit ss, input int band,
                     input string tag);
    step(e, ld, ss, band, 1'b0, 0, 0, 1'b0, 0, 0, tag);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 12; i++) begin st[i] = 0; act[i] = 0; end
    st[11] = 4095; act[11] = 4095;
    m_acc = 0; m_p = 0; m_ec = 0; m_ep = 0; last_duty = 0;

    repeat (3) @(negedge clk);
    chk("R1 duty in reset", longint'(duty), 0);
    chk("R1 valid in reset", longint'(duty_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 duty after reset", longint'(duty), 0);
    chk("R1 valid after reset", longint'(duty_valid), 0);
    run(1000, 0, 0, 0, "R1 zero state");

    // R3 integrator alone
    do_write(0, 4);
    run(100, 0, 0, 0, "R3");
    run(-30, 0, 0, 0, "R3");
    run(500, 0, 0, 0, "R3");

    // R4 pole/zero branch
    do_write(1, 16); do_write(2, 128); do_write(3, 192);
    run(200, 0, 0, 0, "R4");
    run(-150, 0, 0, 0, "R4");
    run(-1, 0, 0, 0, "R4");
    run(40, 0, 0, 0, "R4");

    // R5 band scaling
    for (int b = 0; b < 4; b++) run(60, 0, 0, b, "R5");

    // R6 clamp window
    do_write(11, 300);
    run(1500, 0, 0, 3, "R6 max");
    do_write(10, 200);
    for (int k = 0; k < 6; k++) run(-2000, 0, 0, 0, "R6 min");
    do_write(10, 400);
    run(-5, 0, 0, 0, "R6 min wins");
    run(2000, 0, 0, 3, "R6 min wins");
    do_write(10, 0); do_write(11, 4095);

    // R7 bank selection by load level
    do_write(4, 1); do_write(5, 2); do_write(6, 0); do_write(7, 64);
    do_write(9, 1000);
    run(300, 500, 0, 0, "R7 light");
    run(300, 1500, 0, 0, "R7 normal");
    run(300, 1000, 0, 0, "R7 at threshold");
    run(300, 999, 0, 0, "R7 below threshold");

    // R9 switching keeps integrator state
    for (int k = 0; k < 4; k++) run(120, (k % 2 == 0) ? 10 : 2000, 0, 1, "R9 toggle");

    // R8 soft start
    do_write(8, 3);
    run(250, 2000, 1, 0, "R8 soft start");
    run(-90, 2000, 1, 2, "R8 soft start");
    run(70, 10, 1, 0, "R8 with light load");
    run(70, 2000, 0, 0, "R9 after soft start");

    // R10 staging
    step(400, 2000, 0, 0, 1'b0, 0, 0, 1'b1, 0, 50, "R10 late write ignored");
    run(400, 2000, 0, 0, "R10 late write taken next");
    step(-300, 2000, 0, 0, 1'b1, 0, 7, 1'b0, 0, 0, "R10 write with strobe");
    step(100, 2000, 1, 0, 1'b1, 8, 1, 1'b0, 0, 0, "R10 R8 gain with strobe");

    // R11 saturation both ways
    do_write(0, 255); do_write(1, 0); do_write(2, 0); do_write(3, 0); do_write(9, 0);
    for (int k = 0; k < 20; k++) run(2047, 0, 0, 0, "R11 positive");
    for (int k = 0; k < 40; k++) run(-2048, 0, 0, 0, "R11 negative");
    do_write(10, 0);
    run(2047, 0, 0, 0, "R11 recover");

    // constrained random mix
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(7) == 0) do_write($urandom_range(7), $urandom_range(31));
      if ($urandom_range(15) == 0) do_write($urandom_range(3) * 2 + 2, $urandom_range(255));
      if ($urandom_range(31) == 0) do_write(10, $urandom_range(500));
      if ($urandom_range(31) == 0) do_write(11, 3000 + $urandom_range(1095));
      if ($urandom_range(31) == 0) do_write(9, $urandom_range(4095));
      run(longint'($urandom_range(4095)) - 2048, longint'($urandom_range(4095)),
          ($urandom_range(7) == 0), int'($urandom_range(3)), "R3 R4 random");
    end

    report();
  end
endmodule